// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block merges eight edge-sensitive request lines into one interrupt output toward a processor. Each line has a mask bit. A rising edge on an unmasked line latches a request, and fixed priority picks the lowest-numbered eligible line. When the processor acknowledges, the block either presents an 8-bit vector equal to a programmed base plus the line number, or, when it acts as a master and the winning line has a slave attached, it names that line on a small cascade bus so the slave can present its own vector. Lines being served are tracked in an in-service register, and an end-of-interrupt command releases them.

Software programs the block through a byte-wide write port with a two-bit register select. A fixed sequence of initialization words sets the vector base, the cascade wiring and the operating mode. After that sequence, writes to the data port load the mask, and writes to the command port carry end-of-interrupt commands. A static strap input chooses master or slave behaviour. Two instances can be joined into a fifteen-source system: the slave's interrupt output drives one master line, and the master's cascade outputs feed the slave's cascade inputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `casc_out_valid` are 0, all request and in-service bits are clear, and the mask is all ones, so edges on any line stay ignored until software writes the mask.
- R2: A command-port write (`wr_sel`=0) with bit 4 set starts initialization from any state and clears all request and in-service bits. Its bit 1 set means a single controller: the cascade word is skipped and the cascade setting cleared. Its bit 0 set means a mode word follows. Data-port writes (`wr_sel`=1) then load the base, then the cascade word if expected, then the mode word if expected. Only after that do data-port writes load the mask. `int_out` stays 0 until the sequence completes.
- R3: Mask bit n at 1 makes the block ignore line n: a rising edge on it latches nothing, even if the bit is cleared later. Mask bit n at 0 lets it through.
- R4: A rising edge on an unmasked line latches a request. The request stays set after the input falls, until the line is acknowledged or initialization restarts. An input held high does not latch again.
- R5: `int_out` is 1 exactly while the block is initialized and some unmasked latched request is eligible.
- R6: Among eligible requests, the lowest-numbered line wins.
- R7: One cycle after an acknowledge with an eligible winner n (and no cascade for n), `vec_valid` is 1 for one cycle with `vec_out` = base + n. Request n clears and in-service bit n sets.
- R8: An in-service bit at line k makes lines k and above ineligible. Lines below k stay eligible.
- R9: A command-port write of 0x20 clears the lowest-numbered set in-service bit. A command-port write of 0x60 plus n clears in-service bit n.
- R10: In master mode (`slave_mode`=0), acknowledging a winner n whose bit is set in the cascade word gives `casc_out_valid`=1 with `casc_out_id`=n one cycle later, instead of a vector.
- R11: In slave mode (`slave_mode`=1) the `ack` input has no effect. A cycle with `casc_in_valid`=1 and `casc_in_id` equal to the low three bits of the cascade word acts as the acknowledge, and the slave never drives the cascade outputs.
- R12: An acknowledge with no eligible request gives no vector and no cascade output, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | 0 command port, 1 data port, others ignored |
| wr_data | input | 8 | Write data |
| irq_lines | input | 8 | Request inputs, rising-edge sensitive |
| slave_mode | input | 1 | Static strap: 1 selects slave behaviour |
| ack | input | 1 | Processor acknowledge pulse (master only) |
| casc_in_valid | input | 1 | Cascade select valid from a master |
| casc_in_id | input | 3 | Cascade line number from a master |
| int_out | output | 1 | Interrupt toward processor or master |
| vec_valid | output | 1 | Vector presented this cycle |
| vec_out | output | 8 | Interrupt vector |
| casc_out_valid | output | 1 | Cascade select toward slaves |
| casc_out_id | output | 3 | Cascaded line number |

## Verification
On every cycle the assertions check that a masked line never gains a request bit, that a request bit only drops on an acknowledge or a restart, and that each acknowledge leaves the winner in service. They also check that a vector and a cascade select never appear together, that every vector follows an acknowledge, that a slave never drives the cascade bus, and that an initialization restart silences the interrupt output. Only the bench scenarios show the rest: the exact vector values, priority and nesting order, which bit each end-of-interrupt form releases, how the init sequence skips words, and the two-hop cascade latency through a real slave instance.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [2:0] {
        CFG_UNINIT,
        CFG_WAIT_BASE,
        CFG_WAIT_CASC,
        CFG_WAIT_MODE,
        CFG_RUN
    } cfg_state_e;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;

    localparam int CMD_INIT_BIT    = 4;
    localparam int CMD_EOI_BIT     = 5;
    localparam int CMD_SPEC_BIT    = 6;
    localparam int INIT_SINGLE_BIT = 1;
    localparam int INIT_MODE_BIT   = 0;

endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter  int N_LINES = 8,
    parameter  int DATA_W  = 8,
    localparam int IDW     = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               run_o,
    output logic [DATA_W-1:0]  base_o,
    output logic [DATA_W-1:0]  casc_o,
    output logic [N_LINES-1:0] mask_o,
    output logic               restart_o,
    output logic               eoi_any_o,
    output logic               eoi_spec_o,
    output logic [IDW-1:0]     eoi_line_o
);

    typedef struct packed {
        cfg_state_e         state;
        logic               single;
        logic               need_mode;
        logic [DATA_W-1:0]  base;
        logic [DATA_W-1:0]  casc;
        logic [N_LINES-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic restart_d, eoi_any_d, eoi_spec_d;

    always_comb begin
        cfg_d      = cfg_q;
        restart_d  = 1'b0;
        eoi_any_d  = 1'b0;
        eoi_spec_d = 1'b0;
        if (wr_en) begin
            if (wr_sel == SEL_CMD) begin
                if (wr_data[CMD_INIT_BIT]) begin
                    restart_d       = 1'b1;
                    cfg_d.state     = CFG_WAIT_BASE;
                    cfg_d.single    = wr_data[INIT_SINGLE_BIT];
                    cfg_d.need_mode = wr_data[INIT_MODE_BIT];
                    cfg_d.casc      = '0;
                end else if (wr_data[CMD_EOI_BIT] && cfg_q.state == CFG_RUN) begin
                    eoi_any_d  = 1'b1;
                    eoi_spec_d = wr_data[CMD_SPEC_BIT];
                end
            end else if (wr_sel == SEL_DATA) begin
                case (cfg_q.state)
                    CFG_WAIT_BASE: begin
                        cfg_d.base = wr_data;
                        if (!cfg_q.single)
                            cfg_d.state = CFG_WAIT_CASC;
                        else if (cfg_q.need_mode)
                            cfg_d.state = CFG_WAIT_MODE;
                        else
                            cfg_d.state = CFG_RUN;
                    end
                    CFG_WAIT_CASC: begin
                        cfg_d.casc  = wr_data;
                        cfg_d.state = cfg_q.need_mode ? CFG_WAIT_MODE : CFG_RUN;
                    end
                    CFG_WAIT_MODE: cfg_d.state = CFG_RUN;
                    CFG_RUN:       cfg_d.mask  = wr_data[N_LINES-1:0];
                    default:       ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.state     <= CFG_UNINIT;
            cfg_q.single    <= 1'b0;
            cfg_q.need_mode <= 1'b0;
            cfg_q.base      <= '0;
            cfg_q.casc      <= '0;
            cfg_q.mask      <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run_o      = (cfg_q.state == CFG_RUN);
    assign base_o     = cfg_q.base;
    assign casc_o     = cfg_q.casc;
    assign mask_o     = cfg_q.mask;
    assign restart_o  = restart_d;
    assign eoi_any_o  = eoi_any_d;
    assign eoi_spec_o = eoi_spec_d;
    assign eoi_line_o = wr_data[IDW-1:0];

endmodule

// File: rtl/pic_line_core.sv
module pic_line_core #(
    parameter  int N_LINES = 8,
    localparam int IDW     = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_i,
    input  logic [N_LINES-1:0] mask_i,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic               take_i,
    input  logic               eoi_any_i,
    input  logic               eoi_spec_i,
    input  logic [IDW-1:0]     eoi_line_i,
    output logic               pend_o,
    output logic               fire_o,
    output logic [IDW-1:0]     win_idx_o
);

    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] req;
        logic [N_LINES-1:0] isr;
    } core_t;

    core_t core_d, core_q;

    logic [N_LINES-1:0] rise, allow, elig, set_bit, eoi_clr;
    logic               blk, win_valid, fire;
    logic [IDW-1:0]     win_idx;

    always_comb begin
        rise = irq_i & ~core_q.prev & ~mask_i & {N_LINES{run_i}};

        blk = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (core_q.isr[i]) blk = 1'b1;
            allow[i] = ~blk;
        end
        elig = core_q.req & ~mask_i & allow;

        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_valid = 1'b1;
                win_idx   = IDW'(i);
            end
        end

        fire    = take_i & win_valid & run_i;
        set_bit = fire ? (N_LINES'(1) << win_idx) : '0;

        eoi_clr = '0;
        if (eoi_any_i) begin
            if (eoi_spec_i)
                eoi_clr = N_LINES'(1) << eoi_line_i;
            else
                eoi_clr = core_q.isr & (~core_q.isr + N_LINES'(1));
        end

        core_d.prev = irq_i;
        core_d.req  = (core_q.req & ~set_bit) | rise;
        core_d.isr  = (core_q.isr & ~eoi_clr) | set_bit;
        if (restart_i) begin
            core_d.req = '0;
            core_d.isr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.prev <= '0;
            core_q.req  <= '0;
            core_q.isr  <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign pend_o    = run_i & (|elig);
    assign fire_o    = fire;
    assign win_idx_o = win_idx;

    // R3: a masked line never gains a request bit
    a_r3_masked_edge_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_q.req & ~$past(core_q.req) & $past(mask_i)) == '0));

    // R4: a request bit only drops on an acknowledge or a restart
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(core_q.req) & ~core_q.req) != '0) |-> ($past(fire) || $past(restart_i)));

    // R7: the acknowledged winner is in service on the next cycle
    a_r7_take_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !restart_i) |=> core_q.isr[$past(win_idx)]);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter  int N_LINES = 8,
    parameter  int DATA_W  = 8,
    localparam int IDW     = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               slave_mode,
    input  logic               ack,
    input  logic               casc_in_valid,
    input  logic [IDW-1:0]     casc_in_id,
    output logic               int_out,
    output logic               vec_valid,
    output logic [DATA_W-1:0]  vec_out,
    output logic               casc_out_valid,
    output logic [IDW-1:0]     casc_out_id
);

    logic               cfg_run, restart, eoi_any, eoi_spec;
    logic [DATA_W-1:0]  cfg_base, cfg_casc;
    logic [N_LINES-1:0] cfg_mask;
    logic [IDW-1:0]     eoi_line, win_idx;
    logic               pend, fire, take;

    pic_cfg_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .run_o      (cfg_run),
        .base_o     (cfg_base),
        .casc_o     (cfg_casc),
        .mask_o     (cfg_mask),
        .restart_o  (restart),
        .eoi_any_o  (eoi_any),
        .eoi_spec_o (eoi_spec),
        .eoi_line_o (eoi_line)
    );

    assign take = slave_mode ? (casc_in_valid && (casc_in_id == cfg_casc[IDW-1:0])) : ack;

    pic_line_core #(.N_LINES(N_LINES)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_lines),
        .mask_i     (cfg_mask),
        .run_i      (cfg_run),
        .restart_i  (restart),
        .take_i     (take),
        .eoi_any_i  (eoi_any),
        .eoi_spec_i (eoi_spec),
        .eoi_line_i (eoi_line),
        .pend_o     (pend),
        .fire_o     (fire),
        .win_idx_o  (win_idx)
    );

    typedef struct packed {
        logic              vv;
        logic [DATA_W-1:0] vec;
        logic              cv;
        logic [IDW-1:0]    cid;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.vv = 1'b0;
        out_d.cv = 1'b0;
        if (fire) begin
            if (!slave_mode && cfg_casc[win_idx]) begin
                out_d.cv  = 1'b1;
                out_d.cid = win_idx;
            end else begin
                out_d.vv  = 1'b1;
                out_d.vec = cfg_base + DATA_W'(win_idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.vv  <= 1'b0;
            out_q.vec <= '0;
            out_q.cv  <= 1'b0;
            out_q.cid <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign int_out        = pend;
    assign vec_valid      = out_q.vv;
    assign vec_out        = out_q.vec;
    assign casc_out_valid = out_q.cv;
    assign casc_out_id    = out_q.cid;

    // R10: vector and cascade select are exclusive
    a_r10_one_output_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && casc_out_valid));

    // R7: a vector always follows an acknowledge
    a_r7_vec_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(take));

    // R11: a slave never drives the cascade bus
    a_r11_slave_no_casc: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slave_mode) |-> !casc_out_valid);

    // R2: a restart silences the interrupt output
    a_r2_restart_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !int_out);

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_wr_en = 1'b0, s_wr_en = 1'b0;
    logic [1:0] m_sel = '0, s_sel = '0;
    logic [7:0] m_data = '0, s_data = '0;
    logic [7:0] m_irq = '0, s_irq = '0;
    logic       ack_m = 1'b0, ack_s = 1'b0;

    logic       m_int, m_vv, m_cv, s_int, s_vv, s_cv;
    logic [7:0] m_vec, s_vec, m_lines;
    logic [2:0] m_cid, s_cid;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    assign m_lines = {m_irq[7:3], s_int, m_irq[1:0]};

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(m_wr_en), .wr_sel(m_sel), .wr_data(m_data),
        .irq_lines(m_lines), .slave_mode(1'b0), .ack(ack_m),
        .casc_in_valid(1'b0), .casc_in_id(3'd0),
        .int_out(m_int), .vec_valid(m_vv), .vec_out(m_vec),
        .casc_out_valid(m_cv), .casc_out_id(m_cid)
    );

    prio_irq_ctrl dut_slv (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_sel(s_sel), .wr_data(s_data),
        .irq_lines(s_irq), .slave_mode(1'b1), .ack(ack_s),
        .casc_in_valid(m_cv), .casc_in_id(m_cid),
        .int_out(s_int), .vec_valid(s_vv), .vec_out(s_vec),
        .casc_out_valid(s_cv), .casc_out_id(s_cid)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_m(input logic [1:0] sel, input logic [7:0] d);
        m_wr_en = 1'b1; m_sel = sel; m_data = d;
        tick();
        m_wr_en = 1'b0;
    endtask

    task automatic wr_s(input logic [1:0] sel, input logic [7:0] d);
        s_wr_en = 1'b1; s_sel = sel; s_data = d;
        tick();
        s_wr_en = 1'b0;
    endtask

    task automatic pulse_ack_m();
        ack_m = 1'b1;
        tick();
        ack_m = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 int_out in reset", {7'd0, m_int}, 8'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 int_out after reset", {7'd0, m_int}, 8'd0);
        chk("R1 vec_valid after reset", {7'd0, m_vv}, 8'd0);
        chk("R1 casc_out_valid after reset", {7'd0, m_cv}, 8'd0);
        m_irq[0] = 1'b1; tick();
        chk("R2 uninitialised block ignores edge", {7'd0, m_int}, 8'd0);
        m_irq[0] = 1'b0; tick();
    endtask

    task automatic t_single_init();
        wr_m(2'd0, 8'h13);
        chk("R2 int_out low during init", {7'd0, m_int}, 8'd0);
        wr_m(2'd1, 8'h20);
        wr_m(2'd1, 8'h01);
        m_irq[3] = 1'b1; tick();
        chk("R1 reset mask ignores edge", {7'd0, m_int}, 8'd0);
        m_irq[3] = 1'b0; tick();
    endtask

    task automatic t_edge_priority();
        wr_m(2'd1, 8'hF0);
        m_irq[3] = 1'b1; tick();
        chk("R5 int_out on unmasked edge", {7'd0, m_int}, 8'd1);
        m_irq[3] = 1'b0; tick();
        chk("R4 request held after fall", {7'd0, m_int}, 8'd1);
        m_irq[1] = 1'b1; tick();
        pulse_ack_m();
        chk("R6 lowest line wins valid", {7'd0, m_vv}, 8'd1);
        chk("R7 vector base plus line", m_vec, 8'h21);
        tick();
        chk("R7 vec_valid one cycle", {7'd0, m_vv}, 8'd0);
        chk("R8 in-service blocks higher line", {7'd0, m_int}, 8'd0);
        m_irq[1] = 1'b0; tick();
    endtask

    task automatic t_nesting_eoi();
        m_irq[0] = 1'b1; tick();
        chk("R8 lower line passes in-service", {7'd0, m_int}, 8'd1);
        pulse_ack_m();
        chk("R8 nested vector", m_vec, 8'h20);
        m_irq[0] = 1'b0;
        wr_m(2'd0, 8'h20);
        chk("R9 non-specific EOI frees lowest only", {7'd0, m_int}, 8'd0);
        wr_m(2'd0, 8'h61);
        chk("R9 specific EOI frees line 1", {7'd0, m_int}, 8'd1);
        pulse_ack_m();
        chk("R7 held request vector", m_vec, 8'h23);
        wr_m(2'd0, 8'h20);
        chk("R9 all served", {7'd0, m_int}, 8'd0);
    endtask

    task automatic t_mask_ignore();
        m_irq[5] = 1'b1; tick();
        chk("R3 masked edge ignored", {7'd0, m_int}, 8'd0);
        wr_m(2'd1, 8'h00);
        chk("R3 unmask shows no latched request", {7'd0, m_int}, 8'd0);
        m_irq[5] = 1'b0; tick();
    endtask

    task automatic t_spurious_ack();
        pulse_ack_m();
        chk("R12 no vector on empty ack", {7'd0, m_vv}, 8'd0);
        chk("R12 no cascade on empty ack", {7'd0, m_cv}, 8'd0);
        m_irq[7] = 1'b1; tick();
        chk("R12 state untouched, new edge served", {7'd0, m_int}, 8'd1);
        pulse_ack_m();
        chk("R12 following vector", m_vec, 8'h27);
        m_irq[7] = 1'b0;
        wr_m(2'd0, 8'h20);
    endtask

    task automatic t_reinit();
        m_irq[6] = 1'b1; tick();
        chk("R5 pending before restart", {7'd0, m_int}, 8'd1);
        wr_m(2'd0, 8'h11);
        chk("R2 restart drops int_out", {7'd0, m_int}, 8'd0);
        wr_m(2'd1, 8'h20);
        wr_m(2'd1, 8'h04);
        wr_m(2'd1, 8'h01);
        chk("R2 restart cleared request", {7'd0, m_int}, 8'd0);
        wr_m(2'd1, 8'hFB);
        m_irq[6] = 1'b0;
        wr_s(2'd0, 8'h11);
        wr_s(2'd1, 8'h28);
        wr_s(2'd1, 8'h02);
        wr_s(2'd1, 8'h01);
        wr_s(2'd1, 8'hEF);
    endtask

    task automatic t_cascade();
        s_irq[4] = 1'b1; tick();
        chk("R5 slave int_out", {7'd0, s_int}, 8'd1);
        tick();
        chk("R10 master sees slave line", {7'd0, m_int}, 8'd1);
        pulse_ack_m();
        chk("R10 cascade select valid", {7'd0, m_cv}, 8'd1);
        chk("R10 cascade line number", {5'd0, m_cid}, 8'd2);
        chk("R10 master gives no vector", {7'd0, m_vv}, 8'd0);
        tick();
        chk("R11 slave vector valid", {7'd0, s_vv}, 8'd1);
        chk("R11 slave vector value", s_vec, 8'h2C);
        wr_s(2'd0, 8'h20);
        wr_m(2'd0, 8'h20);
        s_irq[4] = 1'b0; tick();
    endtask

    task automatic t_slave_ack_ignored();
        s_irq[4] = 1'b1; tick(); tick();
        ack_s = 1'b1; tick(); ack_s = 1'b0;
        tick();
        chk("R11 slave ignores ack input", {7'd0, s_vv}, 8'd0);
        chk("R11 slave request still pending", {7'd0, s_int}, 8'd1);
        pulse_ack_m();
        tick();
        chk("R11 cascade path still serves", s_vec, 8'h2C);
        wr_s(2'd0, 8'h20);
        wr_m(2'd0, 8'h20);
        s_irq[4] = 1'b0; tick();
    endtask

    initial begin
        tick(); tick(); tick();
        t_reset();
        t_single_init();
        t_edge_priority();
        t_nesting_eoi();
        t_mask_ignore();
        t_spurious_ack();
        t_reinit();
        t_cascade();
        t_slave_ack_ignored();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule